// File: doc/BRIEF.md
# Wiper Tap Controller with Shutdown

This block keeps the digital state of a 256-position potentiometer wiper. A simple register port reaches two registers: the stored wiper code, and a control register that holds one run/shutdown flag. From them the block drives a per-tap switch enable vector for the resistor array, the settled tap code, and two terminal controls. One control opens the high-end path. The other ties the wiper to the low terminal through a series path.

Whenever the stored code changes during normal operation, the block first closes the switch for the new tap. It keeps the old switch closed as well for a programmable number of clocks, and only then releases the old one. Shutdown leaves the stored code untouched, and leaving shutdown brings the wiper straight back to it. A supply-fail indication seen during shutdown returns the stored code to mid-scale.

Top module: `tap_wiper_ctrl`

## Requirements
- R1: After reset the wiper code reads 0x80, the control register reads 0x40, `tap_sel` is 0x80 and only `tap_en[128]` is set.
- R2: The control register sits at address 0x10. A write keeps only bit 6 (1 = run, 0 = shutdown), and every other bit reads back 0.
- R3: In the cycle after bit 6 is written 0, `hi_open` and `wiper_lo_tie` are 1, `tap_en` is all zero and `tap_sel` is 0x00. While running, both terminal controls are 0.
- R4: The wiper code sits at address 0x00. Shutdown does not change it, writes to it during shutdown are stored, and reads return it in every mode.
- R5: In the cycle after shutdown is released, `tap_sel` equals the stored code and `tap_en` has only that bit set, with no overlap phase.
- R6: While running, a stored code that differs from the settled tap sets the new tap's bit alongside the old one. Both stay set for exactly OVERLAP_CYC cycles, after which only the new bit stays and `tap_sel` takes the new code. Bit i of `tap_en` belongs to code i.
- R7: `tap_en` never has more than two bits set, and it has exactly one set whenever no overlap is in progress while running.
- R8: If the stored code changes during an overlap, that overlap completes first. The next transition then starts from the tap it settled on.
- R9: A `supply_fail` pulse during shutdown sets the stored code to 0x80 and takes priority over a same-cycle write. While running, it has no effect.
- R10: Writes to any address other than 0x00 and 0x10 change nothing, and reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| supply_fail | input | 1 | Supply-fail indication |
| tap_en | output | 256 | Tap switch enables, bit i closes tap i |
| tap_sel | output | 8 | Settled tap code, 0x00 in shutdown |
| hi_open | output | 1 | Opens the high-terminal path |
| wiper_lo_tie | output | 1 | Ties the wiper to the low terminal |

## Verification
The bench builds the block with OVERLAP_CYC set to 3, so that a wrong overlap length shows up as a distinct cycle count instead of coinciding with the default of 2. With that window, a code written one cycle into an overlap lands while the overlap is still open, which brings the queued-transition case of R8 within reach. Shutdown entry and exit are also driven with writes and supply-fail pulses on adjacent cycles.

// File: rtl/tapw_pkg.sv
package tapw_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned POS_ADDR = 8'h00;
    localparam int unsigned CTL_ADDR = 8'h10;
    localparam int unsigned RUN_BIT  = 6;

    function automatic int unsigned mid_code(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction
endpackage

// File: rtl/tapw_regs.sv
module tapw_regs
    import tapw_pkg::*;
#(
    parameter int unsigned TAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TAP_W-1:0]  wdata_i,
    input  logic              fail_i,
    output logic [TAP_W-1:0]  pos_o,
    output logic [TAP_W-1:0]  pos_nxt_o,
    output logic              run_o,
    output logic [TAP_W-1:0]  rdata_o
);
    localparam logic [TAP_W-1:0] MID = TAP_W'(mid_code(TAP_W));

    typedef struct packed {
        logic [TAP_W-1:0] pos;
        logic             run;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit_pos, hit_ctl;

    always_comb begin
        hit_pos = wr_i && (addr_i == ADDR_W'(POS_ADDR));
        hit_ctl = wr_i && (addr_i == ADDR_W'(CTL_ADDR));
        st_d = st_q;
        if (hit_pos) st_d.pos = wdata_i;
        if (hit_ctl) st_d.run = wdata_i[RUN_BIT];
        if (fail_i && !st_q.run) st_d.pos = MID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= MID;
            st_q.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(POS_ADDR)) rdata_o = st_q.pos;
        else if (addr_i == ADDR_W'(CTL_ADDR)) rdata_o[RUN_BIT] = st_q.run;
    end

    assign pos_o     = st_q.pos;
    assign pos_nxt_o = st_d.pos;
    assign run_o     = st_q.run;

    // R4: shutdown alone never moves the stored code
    a_r4_sd_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !hit_pos && !fail_i) |=> $stable(st_q.pos));
    // R9: supply fail during shutdown recentres the code
    a_r9_fail_recentres: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && !st_q.run) |=> (st_q.pos == MID));
    // R9: supply fail while running is ignored
    a_r9_fail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && st_q.run && !hit_pos) |=> $stable(st_q.pos));
endmodule

// File: rtl/tapw_mbb.sv
module tapw_mbb #(
    parameter int unsigned TAP_W       = 8,
    parameter int unsigned OVERLAP_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic [TAP_W-1:0]        pos_i,
    input  logic [TAP_W-1:0]        pos_nxt_i,
    output logic [(1<<TAP_W)-1:0]   tap_en_o,
    output logic [TAP_W-1:0]        tap_sel_o
);
    localparam int unsigned NTAPS = 1 << TAP_W;
    localparam int unsigned CNT_W = $clog2(OVERLAP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OVERLAP_CYC - 1);
    localparam logic [TAP_W-1:0] MID = TAP_W'(1 << (TAP_W - 1));

    typedef struct packed {
        logic [TAP_W-1:0] cur;
        logic [TAP_W-1:0] nxt;
        logic             ovl;
        logic [CNT_W-1:0] cnt;
    } mbb_t;

    mbb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cur = pos_nxt_i;
            st_d.ovl = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.ovl) begin
            if (st_q.cnt == '0) begin
                st_d.cur = st_q.nxt;
                st_d.ovl = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (pos_i != st_q.cur) begin
            st_d.nxt = pos_i;
            st_d.ovl = 1'b1;
            st_d.cnt = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur <= MID;
            st_q.nxt <= MID;
            st_q.ovl <= 1'b0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NTAPS; i++) begin : g_sw
        assign tap_en_o[i] = run_i &&
            ((st_q.cur == TAP_W'(i)) || (st_q.ovl && (st_q.nxt == TAP_W'(i))));
    end

    assign tap_sel_o = run_i ? st_q.cur : '0;

    // R6: the overlap ends by settling on the tap it was closing
    a_r6_settle_new: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && st_q.ovl && st_q.cnt == '0) |=> (st_q.cur == $past(st_q.nxt)));
    // R5: on leaving shutdown the settled tap is the stored code
    a_r5_exit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (st_q.cur == pos_i && !st_q.ovl));
endmodule

// File: rtl/tap_wiper_ctrl.sv
module tap_wiper_ctrl #(
    parameter int unsigned OVERLAP_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [7:0]   reg_addr,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    input  logic         supply_fail,
    output logic [255:0] tap_en,
    output logic [7:0]   tap_sel,
    output logic         hi_open,
    output logic         wiper_lo_tie
);
    localparam int unsigned TAP_W = 8;

    logic [TAP_W-1:0] pos_q, pos_d;
    logic             run_q;

    tapw_regs #(.TAP_W(TAP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .fail_i    (supply_fail),
        .pos_o     (pos_q),
        .pos_nxt_o (pos_d),
        .run_o     (run_q),
        .rdata_o   (reg_rdata)
    );

    tapw_mbb #(.TAP_W(TAP_W), .OVERLAP_CYC(OVERLAP_CYC)) u_mbb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .pos_i     (pos_q),
        .pos_nxt_i (pos_d),
        .tap_en_o  (tap_en),
        .tap_sel_o (tap_sel)
    );

    assign hi_open      = !run_q;
    assign wiper_lo_tie = !run_q;

    // R7: never more than two switches closed
    a_r7_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_en) <= 2);
    // R3: shutdown leaves every tap switch open
    a_r3_dark_in_sd: assert property (@(posedge clk) disable iff (!rst_n)
        hi_open |-> (tap_en == '0 && wiper_lo_tie));
endmodule

// File: tb/sim_tap_wiper_ctrl.sv
module sim_tap_wiper_ctrl;
    localparam int OVL = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = 8'h00;
    logic [7:0]   reg_wdata = 8'h00;
    logic [7:0]   reg_rdata;
    logic         supply_fail = 1'b0;
    logic [255:0] tap_en;
    logic [7:0]   tap_sel;
    logic         hi_open;
    logic         wiper_lo_tie;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    string tag  = "R1";

    // behavioural model state
    int m_pos = 128, m_cur = 128, m_nxt = 128, m_cnt = 0;
    bit m_run = 1, m_ovl = 0;

    tap_wiper_ctrl #(.OVERLAP_CYC(OVL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .supply_fail(supply_fail),
        .tap_en(tap_en), .tap_sel(tap_sel), .hi_open(hi_open),
        .wiper_lo_tie(wiper_lo_tie)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        int npos;
        bit nrun;
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog (all R): cycles %0d, expected under 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
        if (!rst_n) begin
            m_pos = 128; m_run = 1; m_cur = 128; m_nxt = 128; m_ovl = 0; m_cnt = 0;
        end else begin
            npos = m_pos; nrun = m_run;
            if (reg_wr && reg_addr == 8'h00) npos = reg_wdata;
            if (reg_wr && reg_addr == 8'h10) nrun = reg_wdata[6];
            if (supply_fail && !m_run) npos = 128;
            if (!m_run) begin
                m_cur = npos; m_ovl = 0; m_cnt = 0;
            end else if (m_ovl) begin
                if (m_cnt == 0) begin m_cur = m_nxt; m_ovl = 0; end
                else m_cnt--;
            end else if (m_pos != m_cur) begin
                m_nxt = m_pos; m_ovl = 1; m_cnt = OVL - 1;
            end
            m_pos = npos; m_run = nrun;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h00) return 8'(m_pos);
        if (a == 8'h10) return m_run ? 8'h40 : 8'h00;
        return 8'h00;
    endfunction

    task automatic compare();
        logic [255:0] e_en;
        logic [7:0]   e_sel, e_rd;
        string rtag;
        e_en = '0;
        if (m_run) begin
            e_en[m_cur] = 1'b1;
            if (m_ovl) e_en[m_nxt] = 1'b1;
        end
        e_sel = m_run ? 8'(m_cur) : 8'h00;
        e_rd  = exp_rd(reg_addr);
        rtag  = (reg_addr == 8'h00) ? "R4" : (reg_addr == 8'h10) ? "R2" : "R10";
        vectors++;
        if (tap_en !== e_en) begin
            errors++;
            $display("FAIL %s/R6 tap_en: got %h expected %h", tag, tap_en, e_en);
        end
        if (tap_sel !== e_sel) begin
            errors++;
            $display("FAIL %s/R5 tap_sel: got %h expected %h", tag, tap_sel, e_sel);
        end
        if (hi_open !== !m_run || wiper_lo_tie !== !m_run) begin
            errors++;
            $display("FAIL %s/R3 terminals: got %b%b expected %b%b", tag,
                     hi_open, wiper_lo_tie, !m_run, !m_run);
        end
        if (reg_rdata !== e_rd) begin
            errors++;
            $display("FAIL %s/%s rdata@%h: got %h expected %h", tag, rtag,
                     reg_addr, reg_rdata, e_rd);
        end
        if ($countones(tap_en) > 2 || (m_run && !m_ovl && $countones(tap_en) != 1)) begin
            errors++;
            $display("FAIL %s/R7 bit count: got %0d expected %0d", tag,
                     $countones(tap_en), m_ovl ? 2 : 1);
        end
    endtask

    // one cycle: check outputs at negedge, then set the next inputs
    task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        input bit fail);
        @(negedge clk);
        compare();
        reg_wr = wr; reg_addr = a; reg_wdata = d; supply_fail = fail;
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) step(0, a, 8'h00, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        idle(2, 8'h00);
        idle(2, 8'h10);
        tag = "R6";
        step(1, 8'h00, 8'h05, 0); idle(6, 8'h00);
        step(1, 8'h00, 8'hFF, 0); idle(6, 8'h00);
        step(1, 8'h00, 8'h00, 0); idle(6, 8'h00);
        tag = "R8";
        step(1, 8'h00, 8'h40, 0); idle(1, 8'h00);
        step(1, 8'h00, 8'hC3, 0); idle(10, 8'h00);
        tag = "R2";
        step(1, 8'h10, 8'hFF, 0); idle(2, 8'h10);
        step(1, 8'h10, 8'hBF, 0); idle(2, 8'h10);
        tag = "R3";
        idle(2, 8'h00);
        tag = "R4";
        step(1, 8'h00, 8'h33, 0); idle(2, 8'h00);
        tag = "R9";
        step(0, 8'h00, 8'h00, 1); idle(2, 8'h00);
        step(1, 8'h00, 8'h11, 1); idle(2, 8'h00);
        tag = "R5";
        step(1, 8'h00, 8'h21, 0);
        step(1, 8'h10, 8'h40, 0); idle(6, 8'h00);
        tag = "R9";
        step(0, 8'h00, 8'h00, 1); idle(3, 8'h00);
        tag = "R10";
        step(1, 8'h01, 8'h07, 0); idle(1, 8'h01);
        step(1, 8'h11, 8'h00, 0); idle(1, 8'h11);
        step(1, 8'hFF, 8'h9A, 0); idle(1, 8'hFF); idle(3, 8'h00);
        tag = "R7";
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [7:0] a;
            k = $urandom_range(0, 9);
            a = (k < 5) ? 8'h00 : (k < 7) ? 8'h10 : 8'($urandom_range(1, 255));
            step($urandom_range(0, 2) == 0, a, 8'($urandom),
                 $urandom_range(0, 7) == 0);
        end
        idle(8, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule